// File: doc/BRIEF.md
# DMA Request Detection Controller

This block watches the request pin of one DMA channel and decides, clock by clock, when a bus transfer is launched. It first passes the pin through a synchronizer. It then asks a bus arbiter for the bus through a hold output and launches one single-address transfer per granted cycle. Each launched transfer raises a strobe and the acknowledge together, and the selected transfer size is registered onto an output for the bus sequencer.

The block works in burst mode with one of two detection styles, chosen at run time. In edge mode one rising request starts a burst. The burst then runs to the final transfer while the pin is ignored. In level mode the synchronized pin is sampled every cycle, and each high sample becomes an acceptance in a small queue. Accepted entries are carried out even after the request goes away, so a request dropped just after the first acknowledge still yields four or five transfers. The queue is emptied only when the external transfer counter signals the final transfer. When the queue runs empty, the bus is handed back.

Top module: `dma_req_detect`

## Requirements
- R1: A synchronous active-high reset clears the burst flag, the acceptance queue and the synchronizer. After the reset edge, bus_hold, dack, xfer_stb and burst_done are all low.
- R2: In edge mode (level_mode=0, chan_en=1), a low-to-high change of the synchronized pin starts a burst. bus_hold is high after the third clock edge that follows the pin rising, and it is still low after the second.
- R3: While an edge-mode burst runs, the pin is ignored. Toggling it neither stops the burst nor adds transfers, and exactly the number of transfers set by the transfer counter are performed.
- R4: After an edge-mode burst ends, a pin that stayed high starts no new burst. A later low-then-high change on the pin is detected again, and it raises bus_hold three edges after the pin rises.
- R5: In level mode (level_mode=1, chan_en=1), every clock edge that sees the synchronized pin high adds one acceptance, up to a queue depth of 3. Further high samples are dropped while the queue is full.
- R6: bus_hold is high exactly while work is pending: queued acceptances in level mode, or an unfinished burst in edge mode. In level mode it falls once the queue runs empty.
- R7: The first acknowledge comes no sooner than 3 clock edges after the pin rises. With the grant given at once, it appears after the fourth edge.
- R8: Acceptances already queued are carried out after the pin drops. In level mode with the grant given at once, a pin held high for 4 or 5 cycles gives 4 or 5 transfers respectively, with no done pulse.
- R9: A transfer launched while last_xfer is high is the final one. It empties the queue, ends the burst and drops bus_hold, and burst_done is high for exactly the one cycle after that transfer's acknowledge.
- R10: xfer_size shows the value of size_sel at the edge that launched the current transfer (0 = byte, 1 = word, 2 = longword), and it holds that value between transfers.
- R11: A transfer is launched at an edge only when bus_hold and bus_grant are both high and work is pending. The transfer shows as dack and xfer_stb high together for one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel start conditions met; gates detection |
| level_mode | input | 1 | 1 = level detection, 0 = edge detection |
| dreq_pin | input | 1 | Asynchronous external request |
| size_sel | input | 2 | Transfer size code: 0 byte, 1 word, 2 longword |
| bus_grant | input | 1 | Grant from bus arbiter |
| last_xfer | input | 1 | From transfer counter: next launch is the final one |
| bus_hold | output | 1 | Bus request / hold toward arbiter |
| dack | output | 1 | Acknowledge, high during the DMA bus cycle |
| xfer_stb | output | 1 | One-cycle strobe per transfer toward the sequencer |
| xfer_size | output | 2 | Size code registered at transfer launch |
| burst_done | output | 1 | One-cycle pulse after the final transfer |

## Verification
Each result arrives at a fixed point after its stimulus. bus_hold follows a pin rise after three edges: two synchronizer stages, then the detect register. An acknowledge and its strobe follow the edge that sees hold and grant both high, one register later. burst_done follows the final acknowledge by one further edge. The bench drives inputs and reads outputs on the falling edge. A cycle model in the bench, updated on the rising edge, is compared against every output on each falling edge. The directed cases count falling edges from the stimulus to the exact cycle each result is due.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } xfer_size_e;

  localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], din};
  end

  assign dout = sh[STAGES-1];
endmodule

// File: rtl/dma_accept_queue.sv
module dma_accept_queue #(
  parameter int unsigned DEPTH = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic pop,
  input  logic flush,
  output logic nonempty,
  output logic nonempty_next
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);

  logic [CW-1:0] cnt, cnt_n;
  logic do_push, do_pop;

  assign do_push = push && (cnt != FULLV);
  assign do_pop  = pop && (cnt != '0);

  always_comb begin
    cnt_n = cnt;
    if (flush)                 cnt_n = '0;
    else if (do_push && !do_pop) cnt_n = cnt + 1'b1;
    else if (!do_push && do_pop) cnt_n = cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_n;
  end

  assign nonempty      = (cnt != '0);
  assign nonempty_next = (cnt_n != '0);
endmodule

// File: rtl/dma_req_detect.sv
module dma_req_detect
  import dma_req_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned QDEPTH      = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       chan_en,
  input  logic       level_mode,
  input  logic       dreq_pin,
  input  logic [1:0] size_sel,
  input  logic       bus_grant,
  input  logic       last_xfer,
  output logic       bus_hold,
  output logic       dack,
  output logic       xfer_stb,
  output logic [1:0] xfer_size,
  output logic       burst_done
);
  localparam int unsigned NSTG = (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

  logic smp, smp_prev;
  logic burst_q, burst_n;
  logic q_ne, q_ne_n;
  logic go, end_now, edge_hit, push, last_q;

  dma_req_sync #(.STAGES(NSTG)) u_sync (
    .clk(clk), .rst(rst), .din(dreq_pin), .dout(smp)
  );

  // Work is launched only when the arbiter has granted the held bus
  assign go       = bus_hold && bus_grant && (level_mode ? q_ne : burst_q);
  assign end_now  = go && last_xfer;
  assign edge_hit = !level_mode && chan_en && smp && !smp_prev && !burst_q;
  assign push     = level_mode && chan_en && smp && !end_now;
  assign burst_n  = end_now ? 1'b0 : (burst_q | edge_hit);

  dma_accept_queue #(.DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst(rst),
    .push(push), .pop(level_mode && go), .flush(end_now),
    .nonempty(q_ne), .nonempty_next(q_ne_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_prev   <= 1'b0;
      burst_q    <= 1'b0;
      bus_hold   <= 1'b0;
      dack       <= 1'b0;
      xfer_stb   <= 1'b0;
      xfer_size  <= SZ_BYTE;
      last_q     <= 1'b0;
      burst_done <= 1'b0;
    end else begin
      smp_prev   <= smp;
      burst_q    <= burst_n;
      bus_hold   <= level_mode ? q_ne_n : burst_n;
      dack       <= go;
      xfer_stb   <= go;
      last_q     <= end_now;
      burst_done <= dack && last_q;
      if (go) xfer_size <= size_sel;
    end
  end
endmodule

// File: rtl/dma_req_detect_chk.sv
module dma_req_detect_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] size_sel,
  input logic       bus_grant,
  input logic       bus_hold,
  input logic       dack,
  input logic       xfer_stb,
  input logic [1:0] xfer_size,
  input logic       burst_done
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!dack && !bus_hold && !xfer_stb && !burst_done));

  // R11
  launch_grant_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_stb |-> ($past(bus_grant) && $past(bus_hold) && dack));

  // R9
  done_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    burst_done |-> $past(dack));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    burst_done |=> !burst_done);

  // R6
  hold_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_hold) |-> dack);

  // R7
  hold_before_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_hold) |-> !dack);

  // R10
  size_capture_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_stb |-> (xfer_size == $past(size_sel)));

  // R10
  size_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!xfer_stb && !$past(rst)) |-> $stable(xfer_size));
endmodule

bind dma_req_detect dma_req_detect_chk u_chk (
  .clk(clk), .rst(rst), .size_sel(size_sel), .bus_grant(bus_grant),
  .bus_hold(bus_hold), .dack(dack), .xfer_stb(xfer_stb),
  .xfer_size(xfer_size), .burst_done(burst_done)
);

// File: tb/test_dma_req_detect.sv
module test_dma_req_detect;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chan_en = 1'b1, level_mode = 1'b0, dreq_pin = 1'b0;
  logic [1:0] size_sel = 2'd0;
  logic bus_grant = 1'b0;
  logic last_xfer;
  logic bus_hold, dack, xfer_stb, burst_done;
  logic [1:0] xfer_size;

  int checks = 0, errors = 0;
  int cyc = 0;
  logic allow = 1'b1;
  int next_len = 4;
  int rem = 4;
  int dack_total = 0, done_total = 0;

  always #4 clk = ~clk;

  dma_req_detect i_dma_req_detect (
    .clk(clk), .rst(rst), .chan_en(chan_en), .level_mode(level_mode),
    .dreq_pin(dreq_pin), .size_sel(size_sel), .bus_grant(bus_grant),
    .last_xfer(last_xfer), .bus_hold(bus_hold), .dack(dack),
    .xfer_stb(xfer_stb), .xfer_size(xfer_size), .burst_done(burst_done)
  );

  // Arbiter and transfer-counter stubs
  assign last_xfer = (rem == 1);
  always @(negedge clk) begin
    bus_grant = bus_hold && allow;
    if (rst) rem = next_len;
    else if (dack) rem = (rem <= 1) ? next_len : rem - 1;
    if (dack) dack_total++;
    if (burst_done) done_total++;
  end

  // Reference cycle model built from the requirements
  logic m_s1, m_s2, m_prev, m_burst, m_hold, m_dack, m_last, m_done, m_started;
  logic [1:0] m_size;
  int m_cnt;
  always @(posedge clk) begin
    logic go, endn, hit, psh, bn;
    int cn;
    cyc++;
    m_started <= 1'b1;
    if (rst) begin
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_burst <= 0; m_hold <= 0;
      m_dack <= 0; m_last <= 0; m_done <= 0; m_size <= 2'd0; m_cnt <= 0;
    end else begin
      go   = m_hold && bus_grant && (level_mode ? (m_cnt > 0) : m_burst);
      endn = go && last_xfer;
      hit  = !level_mode && chan_en && m_s2 && !m_prev && !m_burst;
      psh  = level_mode && chan_en && m_s2 && !endn && (m_cnt < 3);
      bn   = endn ? 1'b0 : (m_burst | hit);
      cn   = m_cnt;
      if (endn) cn = 0;
      else begin
        if (psh) cn++;
        if (level_mode && go && m_cnt > 0) cn--;
      end
      m_s1 <= dreq_pin; m_s2 <= m_s1; m_prev <= m_s2;
      m_burst <= bn; m_cnt <= cn;
      m_hold <= level_mode ? (cn > 0) : bn;
      m_dack <= go; m_last <= endn; m_done <= m_dack && m_last;
      if (go) m_size <= size_sel;
    end
  end

  task automatic chk(input logic cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (m_started === 1'b1) begin
      chk(bus_hold === m_hold, "R6 bus_hold", int'(bus_hold), int'(m_hold));
      chk(dack === m_dack, "R11 dack", int'(dack), int'(m_dack));
      chk(xfer_stb === m_dack, "R11 xfer_stb", int'(xfer_stb), int'(m_dack));
      chk(burst_done === m_done, "R9 burst_done", int'(burst_done), int'(m_done));
      chk(xfer_size === m_size, "R10 xfer_size", int'(xfer_size), int'(m_size));
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; dreq_pin = 1'b0; allow = 1'b1; chan_en = 1'b1;
    step(2);
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    if (cyc >= 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int d0, n0;
    void'($urandom(32'h5eed_1234));
    next_len = 6;
    step(2);
    // R1: reset state
    chk(!bus_hold && !dack && !xfer_stb && !burst_done, "R1 reset outputs",
        int'({bus_hold, dack, xfer_stb, burst_done}), 0);
    do_reset();

    // R2/R3/R4: edge mode
    level_mode = 1'b0; size_sel = 2'd2; step(3);
    d0 = dack_total; n0 = done_total;
    dreq_pin = 1'b1; step(2);
    chk(!bus_hold, "R2 hold low after two edges", int'(bus_hold), 0);
    step(1);
    chk(bus_hold, "R2 hold high after third edge", int'(bus_hold), 1);
    dreq_pin = 1'b0; step(1); dreq_pin = 1'b1; step(1); dreq_pin = 1'b0; step(1);
    dreq_pin = 1'b1; step(20);
    chk(dack_total - d0 == 6, "R3 burst length", dack_total - d0, 6);
    chk(done_total - n0 == 1, "R9 one done per burst", done_total - n0, 1);
    d0 = dack_total; step(10);
    chk(!bus_hold && dack_total == d0, "R4 held pin no retrigger", dack_total - d0, 0);
    dreq_pin = 1'b0; step(2); dreq_pin = 1'b1; step(2);
    chk(!bus_hold, "R4 retrigger not early", int'(bus_hold), 0);
    step(1);
    chk(bus_hold, "R4 retrigger detected", int'(bus_hold), 1);
    dreq_pin = 1'b0; step(20);

    // R7/R8: level mode pipelined acceptance
    next_len = 100;
    for (int k = 4; k <= 5; k++) begin
      do_reset(); level_mode = 1'b1; step(3);
      d0 = dack_total; n0 = done_total;
      dreq_pin = 1'b1; step(3);
      chk(!dack, "R7 no ack before fourth edge", int'(dack), 0);
      step(1);
      chk(dack, "R7 first ack after fourth edge", int'(dack), 1);
      step(k - 4);
      dreq_pin = 1'b0; step(12);
      chk(dack_total - d0 == k, "R8 accepted transfers run", dack_total - d0, k);
      chk(done_total == n0, "R8 no flush on drop", done_total - n0, 0);
      chk(!bus_hold, "R6 hold released when empty", int'(bus_hold), 0);
    end

    // R5: queue depth cap
    do_reset(); level_mode = 1'b1; allow = 1'b0; step(3);
    d0 = dack_total;
    dreq_pin = 1'b1; step(8); dreq_pin = 1'b0; step(4);
    chk(bus_hold && dack_total == d0, "R6 hold kept while pending", int'(bus_hold), 1);
    allow = 1'b1; step(10);
    chk(dack_total - d0 == 3, "R5 queue capped at three", dack_total - d0, 3);

    // R9: final transfer flushes leftover acceptances
    next_len = 2;
    do_reset(); level_mode = 1'b1; allow = 1'b0; step(3);
    d0 = dack_total; n0 = done_total;
    dreq_pin = 1'b1; step(3); dreq_pin = 1'b0; step(4);
    allow = 1'b1; step(12);
    chk(dack_total - d0 == 2, "R9 flush leftover", dack_total - d0, 2);
    chk(done_total - n0 == 1, "R9 done pulse", done_total - n0, 1);
    chk(!bus_hold, "R9 hold dropped", int'(bus_hold), 0);

    // Random segments checked against the model (R5, R10, R11)
    for (int s = 0; s < 30; s++) begin
      dreq_pin = 1'b0; allow = 1'b1; chan_en = 1'b1; step(14);
      level_mode = s[0] ^ ($urandom_range(0, 3) == 0);
      next_len = $urandom_range(1, 8);
      for (int c = 0; c < 100; c++) begin
        if ($urandom_range(0, 3) == 0) dreq_pin = ~dreq_pin;
        allow    = ($urandom_range(0, 3) != 0);
        chan_en  = ($urandom_range(0, 9) != 0);
        size_sel = 2'($urandom_range(0, 2));
        if ($urandom_range(0, 15) == 0) next_len = $urandom_range(1, 8);
        step(1);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule